// File: doc/BRIEF.md
# Two-Word Message Mailbox

This block carries short messages between a host processor and an embedded engine. A message is two 32-bit words. The host has a single data address. A host write to it pushes a word toward the engine, and a host read from it pops a word that the engine has sent back. Each direction has its own queue, two words deep by default. The engine sees plain push and pop strobes on its own side.

The host drives one word-addressed register port. Besides the data address it can reach a status word, a control word, a mailbox word and a read-only watch queue. The engine fills the watch queue with 31-bit trace words. The status word holds the level flags and four sticky interrupt flags in its upper half. Software sends a message only when the inbound queue is empty, and it checks the not-full flag before the second word. It treats the send as done once the engine has drained the queue. It polls for a bounded number of intervals before it gives up.

Top module: `msg_mailbox`

## Requirements
- R1: After reset the status word (address 1) reads 0x00060000, with in-not-full at bit 17 and out-not-full at bit 18 set. The control word (address 2) reads 0 and `irq` is low.
- R2: A host write to address 0 pushes the word into the inbound queue only while control bit 17 (inbound enable) is set. Otherwise the write is ignored.
- R3: Each queue holds DEPTH words (default 2). A push into a full queue is dropped. Status bit 19 (in-not-empty) and bit 17 (in-not-full) track the inbound level.
- R4: A host read of address 0 returns the oldest outbound word and pops it in the same cycle. A read of an empty outbound queue returns 0 and changes nothing. Bit 16 is out-not-empty and bit 18 is out-not-full.
- R5: An engine push enters the outbound queue only when control bit 16 (outbound enable) is set and the queue is not full. `eng_out_ready` shows exactly that condition.
- R6: The engine reads the inbound words in the order they were written. `eng_in_pop` removes the head, and `eng_in_valid` falls once the queue is drained.
- R7: Status bit 22 is set when the outbound queue goes from empty to non-empty while control bit 24 is set. Bit 21 is set when the inbound queue drains to empty while control bit 25 is set. Writing 1 to a status flag bit (20 to 23) clears it. `irq` is the OR of bits 20 to 23.
- R8: The mailbox word (address 3) resets to 0x0000F0F0 and a host write loads it. An engine mailbox write loads it, takes priority over a host write in the same cycle, and sets status bit 20.
- R9: A host read of address 4 pops the watch queue. It returns bit 31 set with the word in bits 30:0, or 0 when the queue is empty. Status bit 23 is set when the watch queue goes from empty to non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 3 | Register address: 0 data, 1 status, 2 control, 3 mailbox, 4 watch |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | OR of the sticky interrupt flags |
| eng_in_valid | output | 1 | Inbound queue holds a word |
| eng_in_data | output | 32 | Oldest inbound word |
| eng_in_pop | input | 1 | Engine consumes the inbound head |
| eng_out_push | input | 1 | Engine pushes an outbound word |
| eng_out_data | input | 32 | Outbound word |
| eng_out_ready | output | 1 | Outbound enabled and not full |
| eng_wp_push | input | 1 | Engine pushes a watch word |
| eng_wp_data | input | 31 | Watch word |
| eng_mb_wr | input | 1 | Engine writes the mailbox |
| eng_mb_data | input | 32 | Engine mailbox value |

## Verification
Read data is combinational, so the result of a read is due in the same cycle that the strobe is applied. The pop it causes takes effect at the next rising edge. A push, a control change, a flag set or a flag clear shows at the ports after exactly one rising edge. The bench drives every strobe on a falling edge and removes it on the next falling edge, so each strobe spans exactly one rising edge. It samples the read data, the levels and `irq` on the falling edge that follows. Every check therefore falls half a cycle after the register update it expects.

// File: rtl/msg_mailbox.sv
module msg_mailbox #(
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_cs,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq,
  output logic        eng_in_valid,
  output logic [31:0] eng_in_data,
  input  logic        eng_in_pop,
  input  logic        eng_out_push,
  input  logic [31:0] eng_out_data,
  output logic        eng_out_ready,
  input  logic        eng_wp_push,
  input  logic [30:0] eng_wp_data,
  input  logic        eng_mb_wr,
  input  logic [31:0] eng_mb_data
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NQ = 3;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [31:0] MB_INIT = 32'h0000F0F0;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_MBOX = 3'd3;
  localparam logic [2:0] A_WTCH = 3'd4;

  logic              out_en, in_en, out_ie, in_ie;
  logic [3:0]        flags;
  logic [31:0]       mbox;

  logic [NQ-1:0]          q_push, q_pop;
  logic [NQ-1:0][31:0]    q_wdat, q_head;
  logic [NQ-1:0][CW-1:0]  q_cnt, q_nxt;

  wire host_rd = host_cs & ~host_we;
  wire host_wr = host_cs &  host_we;

  assign q_push[0] = host_wr & (host_addr == A_DATA) & in_en;
  assign q_wdat[0] = host_wdata;
  assign q_pop[0]  = eng_in_pop;

  assign q_push[1] = eng_out_push & out_en;
  assign q_wdat[1] = eng_out_data;
  assign q_pop[1]  = host_rd & (host_addr == A_DATA);

  assign q_push[2] = eng_wp_push;
  assign q_wdat[2] = {1'b0, eng_wp_data};
  assign q_pop[2]  = host_rd & (host_addr == A_WTCH);

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic [31:0]   mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] n;
    logic          do_push, do_pop;

    assign do_push = q_push[i] && (n != FULL);
    assign do_pop  = q_pop[i]  && (n != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp <= '0;
        wp <= '0;
        n  <= '0;
      end else begin
        if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        n <= q_nxt[i];
      end
    end

    always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= q_wdat[i];
    end

    assign q_nxt[i]  = n + CW'(do_push) - CW'(do_pop);
    assign q_cnt[i]  = n;
    assign q_head[i] = (n != '0) ? mem[rp] : '0;
  end

  wire of_set = out_ie && (q_cnt[1] == '0) && (q_nxt[1] != '0);
  wire if_set = in_ie  && (q_cnt[0] != '0) && (q_nxt[0] == '0);
  wire wf_set = (q_cnt[2] == '0) && (q_nxt[2] != '0);
  wire [3:0] f_set = {wf_set, of_set, if_set, eng_mb_wr};
  wire [3:0] f_clr = (host_wr && host_addr == A_STAT) ? host_wdata[23:20] : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en <= 1'b0;
      in_en  <= 1'b0;
      out_ie <= 1'b0;
      in_ie  <= 1'b0;
      flags  <= '0;
      mbox   <= MB_INIT;
    end else begin
      if (host_wr && host_addr == A_CTRL) begin
        out_en <= host_wdata[16];
        in_en  <= host_wdata[17];
        out_ie <= host_wdata[24];
        in_ie  <= host_wdata[25];
      end
      flags <= (flags & ~f_clr) | f_set;
      if (eng_mb_wr)                         mbox <= eng_mb_data;
      else if (host_wr && host_addr == A_MBOX) mbox <= host_wdata;
    end
  end

  wire [31:0] stat_word = {8'b0, flags,
                           q_cnt[0] != '0, q_cnt[1] != FULL,
                           q_cnt[0] != FULL, q_cnt[1] != '0, 16'b0};
  wire [31:0] ctrl_word = {6'b0, in_ie, out_ie, 6'b0, in_en, out_en, 16'b0};

  always_comb begin
    case (host_addr)
      A_DATA:  host_rdata = q_head[1];
      A_STAT:  host_rdata = stat_word;
      A_CTRL:  host_rdata = ctrl_word;
      A_MBOX:  host_rdata = mbox;
      A_WTCH:  host_rdata = (q_cnt[2] != '0) ? {1'b1, q_head[2][30:0]} : 32'b0;
      default: host_rdata = 32'b0;
    endcase
  end

  assign irq           = |flags;
  assign eng_in_valid  = q_cnt[0] != '0;
  assign eng_in_data   = q_head[0];
  assign eng_out_ready = out_en && (q_cnt[1] != FULL);

endmodule

module msg_mailbox_chk #(
  parameter int DEPTH = 2,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_cs,
  input logic          host_we,
  input logic [2:0]    host_addr,
  input logic [31:0]   host_rdata,
  input logic          irq,
  input logic          eng_in_pop,
  input logic          eng_out_push,
  input logic          eng_out_ready,
  input logic          eng_mb_wr,
  input logic          in_en,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt,
  input logic [CW-1:0] wp_cnt
);

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !irq);

  a_r3_in_depth: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= CW'(DEPTH));

  a_r2_disabled_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_we && host_addr == 3'd0 && !in_en && !eng_in_pop)
    |=> $stable(in_cnt));

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && !host_we && host_addr == 3'd0 && out_cnt == '0)
    |-> host_rdata == 32'b0);

  a_r5_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_out_push && !eng_out_ready && !(host_cs && !host_we && host_addr == 3'd0))
    |=> $stable(out_cnt));

  a_r8_mb_irq: assert property (@(posedge clk) disable iff (!rst_n)
    eng_mb_wr |=> irq);

  a_r9_watch_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && !host_we && host_addr == 3'd4 && wp_cnt != '0)
    |-> host_rdata[31]);

endmodule

bind msg_mailbox msg_mailbox_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
  .host_addr(host_addr), .host_rdata(host_rdata), .irq(irq),
  .eng_in_pop(eng_in_pop), .eng_out_push(eng_out_push),
  .eng_out_ready(eng_out_ready), .eng_mb_wr(eng_mb_wr), .in_en(in_en),
  .in_cnt(q_cnt[0]), .out_cnt(q_cnt[1]), .wp_cnt(q_cnt[2])
);

// File: tb/msg_mailbox_test.sv
`timescale 1ns/1ps
module msg_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq, eng_in_valid, eng_out_ready;
  logic [31:0] eng_in_data;
  logic        eng_in_pop = 1'b0, eng_out_push = 1'b0, eng_wp_push = 1'b0, eng_mb_wr = 1'b0;
  logic [31:0] eng_out_data = '0, eng_mb_data = '0;
  logic [30:0] eng_wp_data = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msg_mailbox uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    host_cs = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 0; host_we = 0;
  endtask

  task automatic hread(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_cs = 1; host_we = 0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_cs = 0;
  endtask

  task automatic out_push(logic [31:0] d);
    @(negedge clk); eng_out_push = 1; eng_out_data = d;
    @(negedge clk); eng_out_push = 0;
  endtask

  task automatic in_pop();
    @(negedge clk); eng_in_pop = 1;
    @(negedge clk); eng_in_pop = 0;
  endtask

  task automatic wp_push(logic [30:0] d);
    @(negedge clk); eng_wp_push = 1; eng_wp_data = d;
    @(negedge clk); eng_wp_push = 0;
  endtask

  task automatic mb_write(logic [31:0] d);
    @(negedge clk); eng_mb_wr = 1; eng_mb_data = d;
    @(negedge clk); eng_mb_wr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hread(3'd1, v); check("R1 status", v, 32'h00060000);
    hread(3'd2, v); check("R1 control", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    hread(3'd3, v); check("R8 mailbox reset", v, 32'h0000F0F0);
  endtask

  task automatic t_in_disabled();
    logic [31:0] v;
    hwrite(3'd0, 32'h11111111);
    hread(3'd1, v); check("R2 disabled write status", v, 32'h00060000);
    check("R2 disabled write valid", {31'b0, eng_in_valid}, 32'h0);
  endtask

  task automatic t_inbound();
    logic [31:0] v;
    hwrite(3'd2, 32'h00020000);
    hwrite(3'd0, 32'hA0A0A0A0);
    hread(3'd1, v); check("R3 one word", v, 32'h000E0000);
    hwrite(3'd0, 32'hB1B1B1B1);
    hwrite(3'd0, 32'hC2C2C2C2);
    hread(3'd1, v); check("R3 full status", v, 32'h000C0000);
    check("R6 head first", eng_in_data, 32'hA0A0A0A0);
    in_pop();
    check("R6 head second", eng_in_data, 32'hB1B1B1B1);
    in_pop();
    check("R3 overflow dropped", {31'b0, eng_in_valid}, 32'h0);
    hread(3'd1, v); check("R6 drained status", v, 32'h00060000);
  endtask

  task automatic t_outbound();
    logic [31:0] v;
    hwrite(3'd2, 32'h00030000);
    check("R5 ready when enabled", {31'b0, eng_out_ready}, 32'h1);
    out_push(32'h0000AAAA);
    out_push(32'h0000BBBB);
    check("R5 ready low when full", {31'b0, eng_out_ready}, 32'h0);
    out_push(32'h0000CCCC);
    hread(3'd1, v); check("R4 full status", v, 32'h00030000);
    hread(3'd0, v); check("R4 first read", v, 32'h0000AAAA);
    hread(3'd0, v); check("R4 second read", v, 32'h0000BBBB);
    hread(3'd0, v); check("R4 empty read", v, 32'h0);
    hread(3'd1, v); check("R4 empty status", v, 32'h00060000);
    hwrite(3'd2, 32'h00020000);
    check("R5 ready when disabled", {31'b0, eng_out_ready}, 32'h0);
    out_push(32'h0000DDDD);
    hread(3'd1, v); check("R5 disabled push dropped", v, 32'h00060000);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    hwrite(3'd2, 32'h00030000);
    out_push(32'h00000001);
    check("R7 no irq when disabled", {31'b0, irq}, 32'h0);
    hread(3'd0, v);
    hwrite(3'd2, 32'h03030000);
    hread(3'd2, v); check("R7 control readback", v, 32'h03030000);
    out_push(32'h00000002);
    hread(3'd1, v); check("R7 out flag", v & 32'h00F00000, 32'h00400000);
    check("R7 irq set", {31'b0, irq}, 32'h1);
    hread(3'd0, v);
    hwrite(3'd1, 32'h00400000);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    hwrite(3'd0, 32'h00000003);
    hread(3'd1, v); check("R7 in flag not yet", v & 32'h00F00000, 32'h0);
    in_pop();
    hread(3'd1, v); check("R7 in flag on drain", v & 32'h00F00000, 32'h00200000);
    hwrite(3'd1, 32'h00200000);
    check("R7 in flag cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mailbox();
    logic [31:0] v;
    hwrite(3'd3, 32'h12345678);
    hread(3'd3, v); check("R8 host load", v, 32'h12345678);
    check("R8 host load no irq", {31'b0, irq}, 32'h0);
    mb_write(32'hCAFE0001);
    hread(3'd3, v); check("R8 engine load", v, 32'hCAFE0001);
    hread(3'd1, v); check("R8 mailbox flag", v & 32'h00F00000, 32'h00100000);
    hwrite(3'd1, 32'h00100000);
    check("R8 flag cleared", {31'b0, irq}, 32'h0);
    @(negedge clk);
    host_cs = 1; host_we = 1; host_addr = 3'd3; host_wdata = 32'h0000F0F0;
    eng_mb_wr = 1; eng_mb_data = 32'h00005555;
    @(negedge clk);
    host_cs = 0; host_we = 0; eng_mb_wr = 0;
    hread(3'd3, v); check("R8 engine priority", v, 32'h00005555);
    hwrite(3'd3, 32'h0000F0F0);
    hread(3'd3, v); check("R8 reset value write", v, 32'h0000F0F0);
    hwrite(3'd1, 32'h00F00000);
  endtask

  task automatic t_watch();
    logic [31:0] v;
    hread(3'd4, v); check("R9 empty watch", v, 32'h0);
    wp_push(31'h01234567);
    wp_push(31'h7000000A);
    hread(3'd1, v); check("R9 watch flag", v & 32'h00F00000, 32'h00800000);
    hread(3'd4, v); check("R9 first watch", v, 32'h81234567);
    hread(3'd4, v); check("R9 second watch", v, 32'hF000000A);
    hread(3'd4, v); check("R9 drained watch", v, 32'h0);
    hwrite(3'd1, 32'h00800000);
    check("R9 flag cleared", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_in_disabled();
    t_inbound();
    t_outbound();
    t_irq();
    t_mailbox();
    t_watch();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule